// File: doc/BRIEF.md
# Multicycle Shared-ALU Datapath

This block is the datapath of a small multicycle 32-bit load/store processor. One arithmetic unit does all the work: the PC increment, the branch target sum, effective address sums, register arithmetic and the equality test for branches. One word-addressed array holds both the program and the data. Multiplexers pick the ALU operands, the memory address, the register write target and the register write data. A set of intermediate registers (instruction, memory data, two operand latches and an ALU result latch) carries values from one cycle to the next.

The block has no sequencer. An external controller drives every select and write strobe each cycle. The controller reads back the opcode and function fields of the held instruction, and the zero flag of the live ALU result. The unified memory takes its contents at reset from a parameter image, so a program and its data are in place before the first fetch.

Top module: `mc_datapath`

## Requirements
- R1: When rst_ni is low, the PC, the instruction register, all operand and result latches and every register-file entry clear to zero. The memory array loads the MEM_INIT image, with word i taken from bits [32*i+31:32*i]. After release, opcode_o and funct_o read 0, and the first fetch reads the word at byte address 0.
- R2: On a clock edge with ir_write_i high, the instruction register takes the memory word at the selected address. opcode_o shows IR[31:26] and funct_o shows IR[5:0]. While ir_write_i is low the instruction register holds its value.
- R3: The PC changes only on an edge with pc_write_i high. It loads the live ALU result when pc_src_i is 0 and the ALU result latch when pc_src_i is 1.
- R4: The first operand is the PC when alu_src_a_i is 0 and operand latch A when it is 1. The second operand is chosen by alu_src_b_i: 00 gives operand latch B, 01 gives the constant 4, 10 gives the sign-extended IR[15:0], and 11 gives that value shifted left by two.
- R5: alu_op_i 00 selects add and 01 selects subtract; inside the block these are operation codes 010 and 110. With alu_op_i[1] set, the operation comes from IR[5:0]: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 set-less-than. Any other function value gives add.
- R6: Set-less-than compares the operands as signed values and yields 1 or 0.
- R7: zero_o is high exactly when the live ALU result is all zeros.
- R8: Latch A takes the register indexed by IR[25:21] and latch B the one indexed by IR[20:16]. The write index is IR[15:11] when reg_dst_i is 1 and IR[20:16] when it is 0. Write data is the ALU result latch when mem_to_reg_i is 0 and the memory data latch when it is 1. The write happens on an edge with reg_write_i high.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: The memory address is the PC when iord_i is 0 and the ALU result latch when it is 1. Byte address bits [AW+1:2] index the word. An edge with mem_write_i high stores latch B. Reads are combinational, so a word read in a cycle lands in the instruction or memory data latch at that cycle's closing edge.
- R11: Immediate offsets are sign-extended, so a negative offset from a base register reaches a lower address.
- R12: Latches A, B, the ALU result latch and the memory data latch load on every clock edge, with no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_write_i | input | 1 | PC load strobe |
| ir_write_i | input | 1 | Instruction register load strobe |
| iord_i | input | 1 | Memory address select: 0 PC, 1 ALU result latch |
| mem_write_i | input | 1 | Memory store strobe |
| reg_write_i | input | 1 | Register file write strobe |
| reg_dst_i | input | 1 | Write index select: 1 IR[15:11], 0 IR[20:16] |
| mem_to_reg_i | input | 1 | Write data select: 0 ALU result latch, 1 memory data latch |
| alu_src_a_i | input | 1 | First operand select: 0 PC, 1 latch A |
| alu_src_b_i | input | 2 | Second operand select |
| alu_op_i | input | 2 | 00 add, 01 subtract, 1x from function field |
| pc_src_i | input | 1 | PC source: 0 live ALU result, 1 ALU result latch |
| opcode_o | output | 6 | IR[31:26] |
| funct_o | output | 6 | IR[5:0] |
| zero_o | output | 1 | Live ALU result is zero |

## Verification
The bench builds the block with MEM_WORDS at 64. It passes a MEM_INIT image that holds a 35-word program and a data area at words 48 to 52, so the program and its data stay well apart in one array. It acts as the controller and steps each word through fetch, decode and the sequence its opcode calls for. A probe opcode subtracts the immediate from a chosen register, so each register value can be checked through zero_o. Taken and not-taken branches, a store followed by a load, a write to register 0, a negative offset and signed compares are all observed at the ports.

// File: rtl/mc_dp_pkg.sv
package mc_dp_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned REG_IDX_W = 5;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_fn_e;

  localparam logic [1:0] OPB_REG    = 2'b00;
  localparam logic [1:0] OPB_FOUR   = 2'b01;
  localparam logic [1:0] OPB_IMM    = 2'b10;
  localparam logic [1:0] OPB_IMM_SH = 2'b11;

  localparam logic [1:0] AOP_ADD = 2'b00;
  localparam logic [1:0] AOP_SUB = 2'b01;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;
endpackage

// File: rtl/mc_alu_ctl.sv
module mc_alu_ctl
  import mc_dp_pkg::*;
(
  input  logic [1:0] alu_op_i,
  input  logic [5:0] funct_i,
  output alu_fn_e    fn_o
);
  always_comb begin
    if (alu_op_i == AOP_ADD) begin
      fn_o = ALU_ADD;
    end else if (alu_op_i == AOP_SUB) begin
      fn_o = ALU_SUB;
    end else begin
      unique case (funct_i)
        FN_ADD:  fn_o = ALU_ADD;
        FN_SUB:  fn_o = ALU_SUB;
        FN_AND:  fn_o = ALU_AND;
        FN_OR:   fn_o = ALU_OR;
        FN_SLT:  fn_o = ALU_SLT;
        default: fn_o = ALU_ADD;
      endcase
    end
  end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_dp_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_fn_e      fn_i,
  output logic [W-1:0] res_o,
  output logic         zero_o
);
  always_comb begin
    unique case (fn_i)
      ALU_ADD: res_o = a_i + b_i;
      ALU_SUB: res_o = a_i - b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_SLT: res_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: res_o = '0;
    endcase
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] ra1_i,
  input  logic [IW-1:0] ra2_i,
  input  logic [IW-1:0] wa_i,
  input  logic          we_i,
  input  logic [W-1:0]  wd_i,
  output logic [W-1:0]  rd1_o,
  output logic [W-1:0]  rd2_o
);
  localparam int unsigned N = 1 << IW;

  logic [W-1:0] rf_q [N];

  // entry 0 is never written, so it stays at its reset value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) rf_q[i] <= '0;
    end else if (we_i && (wa_i != '0)) begin
      rf_q[wa_i] <= wd_i;
    end
  end

  assign rd1_o = rf_q[ra1_i];
  assign rd2_o = rf_q[ra2_i];
endmodule

// File: rtl/mc_umem.sv
module mc_umem #(
  parameter int unsigned      W     = 32,
  parameter int unsigned      WORDS = 64,
  parameter logic [WORDS*W-1:0] INIT = '0,
  localparam int unsigned     AW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] idx_i,
  input  logic          we_i,
  input  logic [W-1:0]  wd_i,
  output logic [W-1:0]  rd_o
);
  logic [W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= INIT[i*W +: W];
    end else if (we_i) begin
      mem_q[idx_i] <= wd_i;
    end
  end

  assign rd_o = mem_q[idx_i];
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_dp_pkg::*;
#(
  parameter int unsigned          MEM_WORDS = 64,
  parameter logic [MEM_WORDS*XLEN-1:0] MEM_INIT = '0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pc_write_i,
  input  logic       ir_write_i,
  input  logic       iord_i,
  input  logic       mem_write_i,
  input  logic       reg_write_i,
  input  logic       reg_dst_i,
  input  logic       mem_to_reg_i,
  input  logic       alu_src_a_i,
  input  logic [1:0] alu_src_b_i,
  input  logic [1:0] alu_op_i,
  input  logic       pc_src_i,
  output logic [5:0] opcode_o,
  output logic [5:0] funct_o,
  output logic       zero_o
);
  localparam int unsigned W  = XLEN;
  localparam int unsigned IW = REG_IDX_W;
  localparam int unsigned AW = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1;

  logic [W-1:0] pc_q, ir_q, a_q, b_q, alu_out_q, mdr_q;
  logic [W-1:0] rf_rd1, rf_rd2, mem_rdata;
  logic [W-1:0] imm_ext, opa, opb, alu_res, wr_data, pc_next;
  logic [IW-1:0] wr_idx;
  logic [AW-1:0] mem_idx;
  alu_fn_e       alu_fn;

  assign imm_ext = {{(W-16){ir_q[15]}}, ir_q[15:0]};
  assign opa     = alu_src_a_i ? a_q : pc_q;

  always_comb begin
    unique case (alu_src_b_i)
      OPB_REG:  opb = b_q;
      OPB_FOUR: opb = W'(4);
      OPB_IMM:  opb = imm_ext;
      default:  opb = {imm_ext[W-3:0], 2'b00};
    endcase
  end

  assign mem_idx = iord_i ? alu_out_q[AW+1:2] : pc_q[AW+1:2];
  assign wr_idx  = reg_dst_i ? ir_q[15:11] : ir_q[20:16];
  assign wr_data = mem_to_reg_i ? mdr_q : alu_out_q;
  assign pc_next = pc_src_i ? alu_out_q : alu_res;

  mc_alu_ctl u_alu_ctl (
    .alu_op_i (alu_op_i),
    .funct_i  (ir_q[5:0]),
    .fn_o     (alu_fn)
  );

  mc_alu #(.W(W)) u_alu (
    .a_i    (opa),
    .b_i    (opb),
    .fn_i   (alu_fn),
    .res_o  (alu_res),
    .zero_o (zero_o)
  );

  mc_regfile #(.W(W), .IW(IW)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra1_i  (ir_q[25:21]),
    .ra2_i  (ir_q[20:16]),
    .wa_i   (wr_idx),
    .we_i   (reg_write_i),
    .wd_i   (wr_data),
    .rd1_o  (rf_rd1),
    .rd2_o  (rf_rd2)
  );

  mc_umem #(.W(W), .WORDS(MEM_WORDS), .INIT(MEM_INIT)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_i  (mem_idx),
    .we_i   (mem_write_i),
    .wd_i   (b_q),
    .rd_o   (mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      if (pc_write_i) pc_q <= pc_next;
      if (ir_write_i) ir_q <= mem_rdata;
    end
  end

  // intermediate latches: no enable, valid for one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q       <= '0;
      b_q       <= '0;
      alu_out_q <= '0;
      mdr_q     <= '0;
    end else begin
      a_q       <= rf_rd1;
      b_q       <= rf_rd2;
      alu_out_q <= alu_res;
      mdr_q     <= mem_rdata;
    end
  end

  assign opcode_o = ir_q[31:26];
  assign funct_o  = ir_q[5:0];
endmodule

// File: rtl/mc_dp_checker.sv
module mc_dp_checker
  import mc_dp_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pc_write_i,
  input logic            ir_write_i,
  input logic            pc_src_i,
  input logic            alu_src_a_i,
  input logic [1:0]      alu_src_b_i,
  input logic [1:0]      alu_op_i,
  input logic [XLEN-1:0] pc_q,
  input logic [XLEN-1:0] ir_q,
  input logic [XLEN-1:0] a_q,
  input logic [XLEN-1:0] alu_out_q,
  input logic [XLEN-1:0] mem_rdata
);
  assert_pc_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_write_i |=> $stable(pc_q));

  assert_pc_from_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_write_i && pc_src_i) |=> (pc_q == $past(alu_out_q)));

  assert_pc_plus_four_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_write_i && !pc_src_i && !alu_src_a_i && alu_src_b_i == OPB_FOUR && alu_op_i == AOP_ADD)
    |=> (pc_q == $past(pc_q) + XLEN'(4)));

  assert_ir_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ir_write_i |=> $stable(ir_q));

  assert_ir_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_write_i |=> (ir_q == $past(mem_rdata)));

  assert_r0_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_q[25:21] == '0) |=> (a_q == '0));

  assert_slt_boolean_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_op_i[1] && ir_q[5:0] == FN_SLT) |=> (alu_out_q[XLEN-1:1] == '0));
endmodule

bind mc_datapath mc_dp_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pc_write_i  (pc_write_i),
  .ir_write_i  (ir_write_i),
  .pc_src_i    (pc_src_i),
  .alu_src_a_i (alu_src_a_i),
  .alu_src_b_i (alu_src_b_i),
  .alu_op_i    (alu_op_i),
  .pc_q        (pc_q),
  .ir_q        (ir_q),
  .a_q         (a_q),
  .alu_out_q   (alu_out_q),
  .mem_rdata   (mem_rdata)
);

// File: tb/tb_mc_datapath.sv
module tb_mc_datapath;
  import mc_dp_pkg::*;

  localparam int unsigned MW = 64;
  localparam logic [5:0] OP_R = 6'h00, OP_LW = 6'h23, OP_SW = 6'h2B,
                         OP_BEQ = 6'h04, OP_PRB = 6'h3E, OP_MRK = 6'h3F;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {OP_R, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [MW*32-1:0] mk_img();
    logic [MW*32-1:0] img;
    img = '0;
    img[32*0  +: 32] = enc_i(OP_LW, 0, 1, 'hC0);
    img[32*1  +: 32] = enc_i(OP_PRB, 1, 0, 7);
    img[32*2  +: 32] = enc_i(OP_LW, 0, 2, 'hC4);
    img[32*3  +: 32] = enc_r(1, 2, 3, FN_ADD);
    img[32*4  +: 32] = enc_i(OP_PRB, 3, 0, 12);
    img[32*5  +: 32] = enc_r(1, 2, 4, FN_SUB);
    img[32*6  +: 32] = enc_i(OP_PRB, 4, 0, 2);
    img[32*7  +: 32] = enc_r(1, 2, 5, FN_AND);
    img[32*8  +: 32] = enc_i(OP_PRB, 5, 0, 5);
    img[32*9  +: 32] = enc_r(1, 2, 6, FN_OR);
    img[32*10 +: 32] = enc_i(OP_PRB, 6, 0, 7);
    img[32*11 +: 32] = enc_r(2, 1, 7, FN_SLT);
    img[32*12 +: 32] = enc_i(OP_PRB, 7, 0, 1);
    img[32*13 +: 32] = enc_r(1, 2, 8, FN_SLT);
    img[32*14 +: 32] = enc_i(OP_PRB, 8, 0, 0);
    img[32*15 +: 32] = enc_i(OP_PRB, 8, 0, 1);
    img[32*16 +: 32] = enc_i(OP_SW, 0, 3, 'hC8);
    img[32*17 +: 32] = enc_i(OP_LW, 0, 9, 'hC8);
    img[32*18 +: 32] = enc_i(OP_PRB, 9, 0, 12);
    img[32*19 +: 32] = enc_i(OP_BEQ, 1, 6, 2);
    img[32*20 +: 32] = enc_i(OP_MRK, 0, 0, 0);
    img[32*21 +: 32] = enc_i(OP_MRK, 0, 0, 0);
    img[32*22 +: 32] = enc_i(OP_BEQ, 1, 2, 5);
    img[32*23 +: 32] = enc_r(1, 2, 0, FN_ADD);
    img[32*24 +: 32] = enc_i(OP_PRB, 0, 0, 0);
    img[32*25 +: 32] = enc_i(OP_LW, 0, 11, 'hCC);
    img[32*26 +: 32] = enc_i(OP_LW, 11, 10, -16);
    img[32*27 +: 32] = enc_i(OP_PRB, 10, 0, -3);
    img[32*28 +: 32] = enc_r(10, 1, 12, FN_SLT);
    img[32*29 +: 32] = enc_i(OP_PRB, 12, 0, 1);
    img[32*30 +: 32] = enc_r(1, 10, 13, FN_SLT);
    img[32*31 +: 32] = enc_i(OP_PRB, 13, 0, 0);
    img[32*32 +: 32] = enc_i(OP_BEQ, 0, 8, 1);
    img[32*33 +: 32] = enc_i(OP_MRK, 0, 0, 0);
    img[32*34 +: 32] = enc_i(OP_PRB, 9, 0, 12);
    img[32*48 +: 32] = 32'd7;
    img[32*49 +: 32] = 32'd5;
    img[32*51 +: 32] = 32'hE0;
    img[32*52 +: 32] = 32'hFFFF_FFFD;
    return img;
  endfunction

  localparam logic [MW*32-1:0] IMG = mk_img();

  function automatic string prb_tag(int idx);
    case (idx)
      1, 18:   return "R8 R12 probe";
      4, 6, 8, 10: return "R5 probe";
      12, 14, 29, 31: return "R6 probe";
      15:      return "R7 mismatch probe";
      24:      return "R9 probe";
      27:      return "R11 probe";
      34:      return "R10 probe";
      default: return "R8 probe";
    endcase
  endfunction

  logic clk = 1'b0, rst_n = 1'b0;
  logic pc_write, ir_write, iord, mem_write, reg_write, reg_dst, mem_to_reg;
  logic alu_src_a, pc_src;
  logic [1:0] alu_src_b, alu_op;
  logic [5:0] opcode, funct;
  logic zero;

  always #4ns clk = ~clk;  // 125 MHz

  mc_datapath #(.MEM_WORDS(MW), .MEM_INIT(IMG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pc_write_i(pc_write), .ir_write_i(ir_write),
    .iord_i(iord), .mem_write_i(mem_write), .reg_write_i(reg_write),
    .reg_dst_i(reg_dst), .mem_to_reg_i(mem_to_reg), .alu_src_a_i(alu_src_a),
    .alu_src_b_i(alu_src_b), .alu_op_i(alu_op), .pc_src_i(pc_src),
    .opcode_o(opcode), .funct_o(funct), .zero_o(zero)
  );

  typedef struct {
    string      tag;
    bit         is_zero;
    logic [11:0] val;
  } exp_t;

  exp_t q[$];
  bit   smp = 1'b0;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  logic [31:0] m_rf [32];
  logic [31:0] m_mem [MW];
  logic [31:0] m_pc;

  task automatic push(string tag, bit is_zero, logic [11:0] v);
    exp_t e;
    e.tag = tag; e.is_zero = is_zero; e.val = v;
    q.push_back(e);
    smp = 1'b1;
  endtask

  // monitor: compares mid-cycle, away from the active edge
  always @(negedge clk) begin
    if (smp) begin
      while (q.size() > 0) begin
        exp_t e;
        logic [11:0] got;
        e = q.pop_front();
        got = e.is_zero ? {11'd0, zero} : {opcode, funct};
        checks++;
        if (got !== e.val) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", e.tag, got, e.val);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1ns;
    {pc_write, ir_write, iord, mem_write, reg_write, reg_dst, mem_to_reg, alu_src_a, pc_src} = '0;
    alu_src_b = 2'b00;
    alu_op    = 2'b00;
    smp       = 1'b0;
  endtask

  function automatic logic [31:0] model_fn(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
    case (fn)
      FN_SUB:  return a - b;
      FN_AND:  return a & b;
      FN_OR:   return a | b;
      FN_SLT:  return {31'd0, $signed(a) < $signed(b)};
      default: return a + b;
    endcase
  endfunction

  task automatic run_one(input string ftag, output string ntag);
    logic [31:0] w, a, b, imm, ea;
    int rs, rt, rd;
    bit taken;
    w  = m_mem[m_pc[7:2]];
    rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
    imm = {{16{w[15]}}, w[15:0]};
    a = m_rf[rs]; b = m_rf[rt];
    ea = a + imm;
    ntag = "R2 R3 fetch";
    // fetch and increment
    cyc(); ir_write = 1'b1; pc_write = 1'b1; alu_src_b = OPB_FOUR;
    m_pc = m_pc + 32'd4;
    // decode with speculative branch target
    cyc(); alu_src_b = OPB_IMM_SH; push(ftag, 1'b0, {w[31:26], w[5:0]});
    case (w[31:26])
      OP_R: begin
        cyc(); alu_src_a = 1'b1; alu_op = 2'b10;
        cyc(); reg_write = 1'b1; reg_dst = 1'b1;
        push("R2 IR hold", 1'b0, {w[31:26], w[5:0]});
        if (rd != 0) m_rf[rd] = model_fn(w[5:0], a, b);
      end
      OP_LW: begin
        cyc(); alu_src_a = 1'b1; alu_src_b = OPB_IMM;
        cyc(); iord = 1'b1;
        cyc(); reg_write = 1'b1; mem_to_reg = 1'b1;
        if (rt != 0) m_rf[rt] = m_mem[ea[7:2]];
      end
      OP_SW: begin
        cyc(); alu_src_a = 1'b1; alu_src_b = OPB_IMM;
        cyc(); iord = 1'b1; mem_write = 1'b1;
        m_mem[ea[7:2]] = b;
      end
      OP_BEQ: begin
        taken = (a == b);
        cyc(); alu_src_a = 1'b1; alu_op = AOP_SUB; pc_src = 1'b1; pc_write = taken;
        push("R7 branch compare", 1'b1, {11'd0, taken});
        if (taken) begin
          m_pc = m_pc + {imm[29:0], 2'b00};
          ntag = "R3 R4 taken target";
        end else begin
          ntag = "R3 not-taken hold";
        end
      end
      OP_PRB: begin
        cyc(); alu_src_a = 1'b1; alu_src_b = OPB_IMM; alu_op = AOP_SUB;
        push(prb_tag(int'((m_pc - 32'd4) >> 2)), 1'b1, {11'd0, a == imm});
      end
      default: ;
    endcase
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    string tag, nxt;
    {pc_write, ir_write, iord, mem_write, reg_write, reg_dst, mem_to_reg, alu_src_a, pc_src} = '0;
    alu_src_b = 2'b00;
    alu_op    = 2'b00;
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
    for (int i = 0; i < MW; i++) m_mem[i] = IMG[i*32 +: 32];
    m_pc = '0;
    repeat (3) @(posedge clk);
    #2ns rst_n = 1'b1;
    // R1: idle cycle after reset: IR clear, PC + B = 0 so zero flag high
    cyc();
    push("R1 reset fields", 1'b0, 12'h000);
    push("R1 R7 reset zero", 1'b1, 12'h001);
    tag = "R1 R2 first fetch";
    while (m_pc < 32'd140) begin
      run_one(tag, nxt);
      tag = nxt;
    end
    cyc();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule